// File: doc/BRIEF.md
# Paired Byte Register Bank

This block is the architectural register store of a small 8-bit processor core. Seven byte registers (A, B, C, D, E, H, L) and a flag byte F sit in four 16-bit pairs, AF, BC, DE and HL. Two further 16-bit words serve as the stack pointer (SP) and the program counter (PC). Every pair, including SP and PC, is kept as a high byte and a low byte. A byte write therefore shows up in the pair's 16-bit view on the next cycle, with no copy to keep in step.

The core's decoder reaches the byte registers through a 3-bit operand index. It reaches whole pairs through a 16-bit read/write port. A separate step port increments or decrements one pair per cycle for pointer arithmetic. Reads on both ports are combinational. All updates take effect at the rising clock edge. Operand index 6 names no register. It stands for the memory byte that HL points at, so the block flags a memory-operand request and stores nothing. Instruction decode, memory access and flag arithmetic belong to the surrounding core.

Top module: `regbank_top`

## Requirements
- R1: A synchronous reset, sampled at the rising edge, loads AF=0x0180 (A=0x01, F=0x80), BC=0x0013, DE=0x00D8, HL=0x014D, SP=0xFFFE and PC=0x0100.
- R2: The byte port uses operand index 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A. A byte write stores the 8-bit value in the indexed register, and `byteRdData` returns that register combinationally.
- R3: `pairRdData` is the pair's high register times 256 plus its low register. B, D, H and A are the high halves of BC, DE, HL and AF. A byte write to either half appears in the pair view on the cycle after the write.
- R4: Pair code 0=BC, 1=DE, 2=HL, 3=AF, 4=SP, 5=PC. A pair write loads bits 15:8 into the high register and bits 7:0 into the low register.
- R5: Bits 3:0 of F are stored as zero for every kind of update: pair write, step, and reset.
- R6: A step adds or subtracts one from the selected pair modulo 0x10000, so 0xFFFF steps up to 0x0000 and 0x0000 steps down to 0xFFFF.
- R7: Operand index 6 drives `memReq` high and `byteRdData` to 0x00. A byte write with index 6 leaves every register unchanged.
- R8: When a step and a write (byte or pair) target the same pair in the same cycle, only the step takes effect. Writes to other pairs in that cycle still apply.
- R9: When a pair write and a byte write target the same pair in the same cycle, the pair write wins. When they target different pairs, both apply.
- R10: When `stepInc` and `stepDec` are both high, the pair is incremented.
- R11: Pair codes 6 and 7 and step codes 6 and 7 change nothing, and `pairRdData` reads 0x0000 for pair codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| byteIdx | input | 3 | Operand index for byte read and write |
| byteWrEn | input | 1 | Byte write strobe |
| byteWrData | input | 8 | Byte write value |
| byteRdData | output | 8 | Indexed register, combinational |
| memReq | output | 1 | High while the index selects the memory operand |
| pairSel | input | 3 | Pair code for word read and write |
| pairWrEn | input | 1 | Pair write strobe |
| pairWrData | input | 16 | Pair write value |
| pairRdData | output | 16 | Selected pair, combinational |
| stepInc | input | 1 | Increment strobe |
| stepDec | input | 1 | Decrement strobe |
| stepSel | input | 3 | Pair code for the step |

## Verification
The interesting collision is a step landing on a pair in the same cycle as a byte or pair write that names the same pair. It is provoked by directed cycles that pair a step on HL with a write to H, and a pair write to DE with a byte write to D. It is also provoked by a long run of random strobes in which the step and write selects often coincide. The behavioural model applies the priority order step over pair write over byte write, one pair at a time. After every clock the bench reads back every pair and every byte index and compares each value to that model, so a lost or misordered update shows up on the first cycle it occurs.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WORD_W   = 2 * BYTE_W;
  localparam int unsigned NUM_PAIR = 6;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned MEM_IDX  = 6;
  localparam int unsigned ACC_IDX  = 7;

  typedef enum logic [SEL_W-1:0] {
    PR_BC = 3'd0,
    PR_DE = 3'd1,
    PR_HL = 3'd2,
    PR_AF = 3'd3,
    PR_SP = 3'd4,
    PR_PC = 3'd5
  } pair_e;

  typedef struct packed {
    logic [NUM_PAIR-1:0] ldHi;
    logic [NUM_PAIR-1:0] ldLo;
    logic [NUM_PAIR-1:0] fromWord;
    logic [NUM_PAIR-1:0] stepEn;
    logic                stepDown;
    logic [BYTE_W-1:0]   byteVal;
    logic [WORD_W-1:0]   wordVal;
    logic [SEL_W-1:0]    rdPair;
    logic                rdHi;
    logic                rdValid;
  } bankStrobes_t;

  function automatic logic [WORD_W-1:0] pairResetVal(int unsigned p);
    case (p)
      0:       return 16'h0013;
      1:       return 16'h00D8;
      2:       return 16'h014D;
      3:       return 16'h0180;
      4:       return 16'hFFFE;
      5:       return 16'h0100;
      default: return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pairKeepMask(int unsigned p);
    return (p == int'(PR_AF)) ? 16'hFFF0 : 16'hFFFF;
  endfunction

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    byteIdx,
  input  logic                byteWrEn,
  input  logic [BYTE_W-1:0]   byteWrData,
  input  logic [SEL_W-1:0]    pairSel,
  input  logic                pairWrEn,
  input  logic [WORD_W-1:0]   pairWrData,
  input  logic                stepInc,
  input  logic                stepDec,
  input  logic [SEL_W-1:0]    stepSel,
  output bankStrobes_t        str,
  output logic                memReq
);

  localparam logic [SEL_W-1:0] NP_SEL  = SEL_W'(NUM_PAIR);
  localparam logic [SEL_W-1:0] MEM_SEL = SEL_W'(MEM_IDX);
  localparam logic [SEL_W-1:0] ACC_SEL = SEL_W'(ACC_IDX);

  logic [SEL_W-1:0] tgtPair;
  logic             tgtHi;
  logic             tgtValid;
  logic             stepValid;
  logic [NUM_PAIR-1:0] pairHit;
  logic [NUM_PAIR-1:0] byteHit;

  always_comb begin
    tgtValid = (byteIdx != MEM_SEL);
    if (byteIdx == ACC_SEL) begin
      tgtPair = SEL_W'(PR_AF);
      tgtHi   = 1'b1;
    end else begin
      tgtPair = {1'b0, byteIdx[SEL_W-1:1]};
      tgtHi   = ~byteIdx[0];
    end
  end

  assign stepValid = (stepInc | stepDec) && (stepSel < NP_SEL);
  assign memReq    = (byteIdx == MEM_SEL);

  for (genvar p = 0; p < int'(NUM_PAIR); p++) begin : g_pair
    assign str.stepEn[p] = stepValid && (stepSel == SEL_W'(p));
    assign pairHit[p]    = pairWrEn && (pairSel == SEL_W'(p)) && !str.stepEn[p];
    assign byteHit[p]    = byteWrEn && tgtValid && (tgtPair == SEL_W'(p))
                           && !str.stepEn[p] && !pairHit[p];
    assign str.ldHi[p]     = pairHit[p] | (byteHit[p] & tgtHi);
    assign str.ldLo[p]     = pairHit[p] | (byteHit[p] & ~tgtHi);
    assign str.fromWord[p] = pairHit[p];
  end

  assign str.stepDown = ~stepInc;
  assign str.byteVal  = byteWrData;
  assign str.wordVal  = pairWrData;
  assign str.rdPair   = tgtPair;
  assign str.rdHi     = tgtHi;
  assign str.rdValid  = tgtValid;

  // R8
  step_beats_write_chk: assert property (@(posedge clk) disable iff (rst)
    (str.stepEn & (str.ldHi | str.ldLo)) == '0);

  // R7
  mem_operand_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    memReq |-> ((str.ldHi | str.ldLo) & ~str.fromWord) == '0);

  // R10
  inc_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (stepInc && stepDec) |-> !str.stepDown);

  // R11
  step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(str.stepEn));

endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  bankStrobes_t        str,
  input  logic [SEL_W-1:0]    pairSel,
  output logic [BYTE_W-1:0]   byteRdData,
  output logic [WORD_W-1:0]   pairRdData
);

  logic [NUM_PAIR-1:0][WORD_W-1:0] pairVal;

  for (genvar p = 0; p < int'(NUM_PAIR); p++) begin : g_pair
    localparam logic [WORD_W-1:0] KEEP   = pairKeepMask(p);
    localparam logic [WORD_W-1:0] PWRVAL = pairResetVal(p);
    logic [WORD_W-1:0] val;

    always_ff @(posedge clk) begin
      if (rst) begin
        val <= PWRVAL & KEEP;
      end else if (str.stepEn[p]) begin
        val <= (str.stepDown ? (val - 1'b1) : (val + 1'b1)) & KEEP;
      end else begin
        if (str.ldHi[p])
          val[WORD_W-1:BYTE_W] <= str.fromWord[p] ? str.wordVal[WORD_W-1:BYTE_W] : str.byteVal;
        if (str.ldLo[p])
          val[BYTE_W-1:0] <= (str.fromWord[p] ? str.wordVal[BYTE_W-1:0] : str.byteVal)
                             & KEEP[BYTE_W-1:0];
      end
    end

    assign pairVal[p] = val;

    if (p == int'(PR_AF)) begin : g_flag
      // R5
      flag_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        val[3:0] == 4'h0);
    end else begin : g_plain
      // R6
      wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(str.stepEn[p]) && !$past(str.stepDown)
         && $past(val) == 16'hFFFF) |-> val == 16'h0000);
      // R6
      wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(str.stepEn[p]) && $past(str.stepDown)
         && $past(val) == 16'h0000) |-> val == 16'hFFFF);
    end
  end

  always_comb begin
    pairRdData = '0;
    for (int p = 0; p < int'(NUM_PAIR); p++)
      if (pairSel == SEL_W'(p)) pairRdData = pairVal[p];
  end

  always_comb begin
    byteRdData = '0;
    if (str.rdValid)
      for (int p = 0; p < int'(NUM_PAIR); p++)
        if (str.rdPair == SEL_W'(p))
          byteRdData = str.rdHi ? pairVal[p][WORD_W-1:BYTE_W] : pairVal[p][BYTE_W-1:0];
  end

  // R1
  pc_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> pairVal[PR_PC] == 16'h0100);

  // R8
  quiet_pair_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(str.stepEn[PR_SP]) && !$past(str.ldHi[PR_SP])
     && !$past(str.ldLo[PR_SP])) |-> $stable(pairVal[PR_SP]));

endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    byteIdx,
  input  logic                byteWrEn,
  input  logic [BYTE_W-1:0]   byteWrData,
  output logic [BYTE_W-1:0]   byteRdData,
  output logic                memReq,
  input  logic [SEL_W-1:0]    pairSel,
  input  logic                pairWrEn,
  input  logic [WORD_W-1:0]   pairWrData,
  output logic [WORD_W-1:0]   pairRdData,
  input  logic                stepInc,
  input  logic                stepDec,
  input  logic [SEL_W-1:0]    stepSel
);

  bankStrobes_t str;

  regbank_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .byteIdx    (byteIdx),
    .byteWrEn   (byteWrEn),
    .byteWrData (byteWrData),
    .pairSel    (pairSel),
    .pairWrEn   (pairWrEn),
    .pairWrData (pairWrData),
    .stepInc    (stepInc),
    .stepDec    (stepDec),
    .stepSel    (stepSel),
    .str        (str),
    .memReq     (memReq)
  );

  regbank_dp u_dp (
    .clk        (clk),
    .rst        (rst),
    .str        (str),
    .pairSel    (pairSel),
    .byteRdData (byteRdData),
    .pairRdData (pairRdData)
  );

endmodule

// File: tb/tb_regbank_top.sv
`timescale 1ns/100ps
module tb_regbank_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  byteIdx;
  logic        byteWrEn;
  logic [7:0]  byteWrData;
  logic [7:0]  byteRdData;
  logic        memReq;
  logic [2:0]  pairSel;
  logic        pairWrEn;
  logic [15:0] pairWrData;
  logic [15:0] pairRdData;
  logic        stepInc;
  logic        stepDec;
  logic [2:0]  stepSel;

  always #4 clk = ~clk;

  regbank_top dut (
    .clk(clk), .rst(rst),
    .byteIdx(byteIdx), .byteWrEn(byteWrEn), .byteWrData(byteWrData),
    .byteRdData(byteRdData), .memReq(memReq),
    .pairSel(pairSel), .pairWrEn(pairWrEn), .pairWrData(pairWrData),
    .pairRdData(pairRdData),
    .stepInc(stepInc), .stepDec(stepDec), .stepSel(stepSel)
  );

  logic [15:0] model [6];
  int nChecks = 0;
  int nFails  = 0;

  task automatic modelReset();
    model[0] = 16'h0013; model[1] = 16'h00D8; model[2] = 16'h014D;
    model[3] = 16'h0180; model[4] = 16'hFFFE; model[5] = 16'h0100;
  endtask

  function automatic logic [7:0] expByte(int idx);
    if (idx == 6) return 8'h00;
    if (idx == 7) return model[3][15:8];
    return (idx % 2 == 0) ? model[idx/2][15:8] : model[idx/2][7:0];
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic scanAll(string tag);
    for (int p = 0; p < 8; p++) begin
      pairSel = 3'(p);
      #0.2;
      check(tag, $sformatf("pair%0d", p), pairRdData, (p < 6) ? model[p] : 16'h0000);
    end
    for (int i = 0; i < 8; i++) begin
      byteIdx = 3'(i);
      #0.2;
      check(tag, $sformatf("byte%0d", i), {8'h00, byteRdData}, {8'h00, expByte(i)});
      check(tag, $sformatf("memReq%0d", i), {15'h0, memReq}, {15'h0, (i == 6)});
    end
  endtask

  task automatic idleInputs();
    byteWrEn = 0; pairWrEn = 0; stepInc = 0; stepDec = 0;
    byteIdx = 0; byteWrData = 0; pairSel = 0; pairWrData = 0; stepSel = 0;
  endtask

  task automatic doCycle(string tag,
                         logic bWe, logic [2:0] bIdx, logic [7:0] bD,
                         logic pWe, logic [2:0] pSel, logic [15:0] pD,
                         logic inc, logic dec, logic [2:0] sSel);
    int stepP;
    int pairP;
    int byteP;
    bit byteHi;
    byteWrEn = bWe; byteIdx = bIdx; byteWrData = bD;
    pairWrEn = pWe; pairSel = pSel; pairWrData = pD;
    stepInc = inc; stepDec = dec; stepSel = sSel;
    @(posedge clk);
    stepP = ((inc || dec) && sSel < 6) ? int'(sSel) : -1;
    pairP = (pWe && pSel < 6 && int'(pSel) != stepP) ? int'(pSel) : -1;
    byteP = -1;
    byteHi = 0;
    if (bWe && bIdx != 3'd6) begin
      byteP  = (bIdx == 3'd7) ? 3 : int'(bIdx) / 2;
      byteHi = (bIdx == 3'd7) || (bIdx[0] == 1'b0);
      if (byteP == stepP || byteP == pairP) byteP = -1;
    end
    if (stepP >= 0) model[stepP] = inc ? model[stepP] + 16'd1 : model[stepP] - 16'd1;
    if (pairP >= 0) model[pairP] = pD;
    if (byteP >= 0) begin
      if (byteHi) model[byteP][15:8] = bD;
      else        model[byteP][7:0]  = bD;
    end
    model[3][3:0] = 4'h0;
    @(negedge clk);
    idleInputs();
    scanAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    idleInputs();
    rst = 1'b1;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values, F low nibble included
    scanAll("R1");

    // R2: byte writes by operand index
    doCycle("R2", 1, 3'd0, 8'hA1, 0, 0, 0, 0, 0, 0);
    doCycle("R2", 1, 3'd1, 8'hB2, 0, 0, 0, 0, 0, 0);
    doCycle("R2", 1, 3'd2, 8'hC3, 0, 0, 0, 0, 0, 0);
    doCycle("R2", 1, 3'd3, 8'hD4, 0, 0, 0, 0, 0, 0);
    doCycle("R2", 1, 3'd4, 8'hE5, 0, 0, 0, 0, 0, 0);
    doCycle("R2", 1, 3'd5, 8'hF6, 0, 0, 0, 0, 0, 0);
    doCycle("R2", 1, 3'd7, 8'h77, 0, 0, 0, 0, 0, 0);
    // R3: high half written alone, pair view follows
    doCycle("R3", 1, 3'd0, 8'h5A, 0, 0, 0, 0, 0, 0);
    doCycle("R3", 1, 3'd5, 8'h00, 0, 0, 0, 0, 0, 0);

    // R4: pair writes
    doCycle("R4", 0, 0, 0, 1, 3'd0, 16'h1234, 0, 0, 0);
    doCycle("R4", 0, 0, 0, 1, 3'd1, 16'hBEEF, 0, 0, 0);
    doCycle("R4", 0, 0, 0, 1, 3'd2, 16'h8001, 0, 0, 0);
    doCycle("R4", 0, 0, 0, 1, 3'd4, 16'hFFFF, 0, 0, 0);
    doCycle("R4", 0, 0, 0, 1, 3'd5, 16'h0000, 0, 0, 0);
    // R5: F low nibble dropped on pair write and on step
    doCycle("R5", 0, 0, 0, 1, 3'd3, 16'h12FF, 0, 0, 0);
    doCycle("R5", 0, 0, 0, 0, 0, 0, 1, 0, 3'd3);

    // R6: wrap both ways
    doCycle("R6", 0, 0, 0, 0, 0, 0, 1, 0, 3'd4);
    doCycle("R6", 0, 0, 0, 0, 0, 0, 0, 1, 3'd5);
    doCycle("R6", 0, 0, 0, 0, 0, 0, 1, 0, 3'd0);

    // R7: memory operand index stores nothing
    doCycle("R7", 1, 3'd6, 8'h99, 0, 0, 0, 0, 0, 0);

    // R8: step and byte write on same pair; other pair still written
    doCycle("R8", 1, 3'd4, 8'h3C, 0, 0, 0, 1, 0, 3'd2);
    doCycle("R8", 1, 3'd0, 8'h3C, 1, 3'd0, 16'h4444, 0, 1, 3'd0);
    doCycle("R8", 1, 3'd3, 8'h11, 0, 0, 0, 0, 1, 3'd2);

    // R9: pair write against byte write
    doCycle("R9", 1, 3'd2, 8'h66, 1, 3'd1, 16'hCAFE, 0, 0, 0);
    doCycle("R9", 1, 3'd3, 8'h55, 1, 3'd0, 16'h0F0F, 0, 0, 0);

    // R10: both step strobes
    doCycle("R10", 0, 0, 0, 0, 0, 0, 1, 1, 3'd1);

    // R11: unused pair and step codes
    doCycle("R11", 0, 0, 0, 1, 3'd6, 16'h1111, 0, 0, 0);
    doCycle("R11", 0, 0, 0, 1, 3'd7, 16'h2222, 1, 0, 3'd7);
    doCycle("R11", 0, 0, 0, 0, 0, 0, 0, 1, 3'd6);

    // R8 and R9 under mixed random traffic
    for (int n = 0; n < 500; n++) begin
      doCycle("R8",
              1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 8'($urandom),
              1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 16'($urandom),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
    end

    // R1: reset again in mid-run
    rst = 1'b1;
    @(posedge clk);
    modelReset();
    @(negedge clk);
    rst = 1'b0;
    scanAll("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule